// File: doc/BRIEF.md
# Cascadable Presettable Binary Counter

A small synchronous up-counter. Each bit updates on the rising clock edge, so the outputs never ripple. The counter can be preset from a data word. It can be cleared to zero. It counts only when two separate enables are both high. A carry output marks the top count, and that carry is gated by only one of the two enables. This lets several stages chain into one wider counter with no extra logic. Feed a stage's carry into the next stage's gating enable, and tie the other enable of every stage to a shared count enable.

The parameter `ASYNC_CLEAR` selects how the clear acts.
- When it is 1, the clear acts at once, with no clock.
- When it is 0, the clear takes effect on the next rising edge. In this mode a decoded count can drive the clear to shorten the counting cycle. The counter then runs through N states when the clear is asserted at count N-1.

The priority of operations is clear, then load, then count, then hold.

Top module: `casc_counter`

## Requirements
- R1: With ASYNC_CLEAR=1, a low `clearN` forces `count` to zero immediately, without waiting for a clock edge, whatever `loadN`, `enP` and `enT` are.
- R2: With ASYNC_CLEAR=0, a low `clearN` leaves `count` unchanged until the next rising edge, and that edge sets it to zero whatever `loadN`, `enP` and `enT` are.
- R3: With `clearN` high and `loadN` low, the next rising edge copies `dataIn` into `count` whatever the levels of `enP` and `enT`.
- R4: With `clearN` and `loadN` high and both `enP` and `enT` high, each rising edge adds one to `count`; all ones wraps to zero.
- R5: With `clearN` and `loadN` high and either enable low, `count` holds its value across the edge.
- R6: `carryOut` is high exactly when `enT` is high and `count` is all ones; it follows `enT` without waiting for a clock edge.
- R7: Two instances form one 8-bit synchronous counter. The lower stage has `enP` and `enT` tied to a shared enable. The upper stage has `enP` tied to the shared enable and `enT` driven by the lower stage's `carryOut`. The upper count is the high nibble of the 8-bit value, which advances by one per enabled edge and holds when the shared enable is low.
- R8: With ASYNC_CLEAR=0, both enables high, `loadN` high, and `clearN` driven low whenever `count` equals N-1, the counter cycles 0, 1, …, N-1, 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| clearN | input | 1 | Active-low clear (immediate or edge-timed, by parameter) |
| loadN | input | 1 | Active-low synchronous preset |
| enP | input | 1 | Count enable that gates counting only |
| enT | input | 1 | Count enable that also gates the carry |
| dataIn | input | WIDTH | Preset value |
| count | output | WIDTH | Current count |
| carryOut | output | 1 | High when `enT` is high and the count is all ones |

## Verification
Two things are hard to see from the ports.

The first is the difference between the two clear styles. It shows only when `clearN` falls between clock edges. The stimulus therefore preloads a non-zero value into both a synchronous-clear instance and an immediate-clear instance. It then lowers the clears in mid-period and samples both counts before the next edge. One count must already be zero and the other must not have moved.

The second is the upper-stage carry in the cascade. That path is exercised only at 255 and at each low-nibble rollover. A long enabled run therefore drives the pair through a full 256-state cycle, with pauses in the shared enable, so that a wrong gating of the carry shows up.

// File: rtl/casc_counter_pkg.sv
package casc_counter_pkg;

  // Strobes from the control decode to the datapath register.
  typedef struct packed {
    logic doClear;
    logic doLoad;
    logic doInc;
  } ctrlStrobe_t;

  typedef enum logic [1:0] {
    OP_CLEAR = 2'd0,
    OP_LOAD  = 2'd1,
    OP_COUNT = 2'd2,
    OP_HOLD  = 2'd3
  } counterOp_e;

endpackage

// File: rtl/casc_counter_ctrl.sv
module casc_counter_ctrl
  import casc_counter_pkg::*;
(
  input  logic        clearN,
  input  logic        loadN,
  input  logic        enP,
  input  logic        enT,
  output ctrlStrobe_t strobe
);

  counterOp_e op;

  // Fixed priority: clear, load, count, hold.
  always_comb begin
    if (!clearN)          op = OP_CLEAR;
    else if (!loadN)      op = OP_LOAD;
    else if (enP && enT)  op = OP_COUNT;
    else                  op = OP_HOLD;
  end

  always_comb begin
    strobe         = '0;
    strobe.doClear = (op == OP_CLEAR);
    strobe.doLoad  = (op == OP_LOAD);
    strobe.doInc   = (op == OP_COUNT);
  end

endmodule

// File: rtl/casc_counter_dp.sv
module casc_counter_dp
  import casc_counter_pkg::*;
#(
  parameter int WIDTH       = 4,
  parameter bit ASYNC_CLEAR = 1'b0
) (
  input  logic             clk,
  input  logic             asyncClrN,
  input  ctrlStrobe_t      strobe,
  input  logic [WIDTH-1:0] dataIn,
  input  logic             enT,
  output logic [WIDTH-1:0] count,
  output logic             carryOut
);

  localparam logic [WIDTH-1:0] TERMINAL = {WIDTH{1'b1}};
  localparam logic [WIDTH-1:0] ONE      = {{(WIDTH-1){1'b0}}, 1'b1};

  logic [WIDTH-1:0] cntQ;
  logic [WIDTH-1:0] cntNext;

  always_comb begin
    cntNext = cntQ;
    if (strobe.doClear)     cntNext = '0;
    else if (strobe.doLoad) cntNext = dataIn;
    else if (strobe.doInc)  cntNext = cntQ + ONE;
  end

  generate
    if (ASYNC_CLEAR) begin : g_asyncClr
      always_ff @(posedge clk or negedge asyncClrN) begin
        if (!asyncClrN) cntQ <= '0;
        else            cntQ <= cntNext;
      end
    end else begin : g_syncClr
      // asyncClrN is tied high by the top in this variant.
      always_ff @(posedge clk) begin
        if (!asyncClrN) cntQ <= '0;
        else            cntQ <= cntNext;
      end
    end
  endgenerate

  assign count    = cntQ;
  assign carryOut = enT & (cntQ == TERMINAL);

endmodule

// File: rtl/casc_counter.sv
module casc_counter
  import casc_counter_pkg::*;
#(
  parameter int WIDTH       = 4,
  parameter bit ASYNC_CLEAR = 1'b0
) (
  input  logic             clk,
  input  logic             clearN,
  input  logic             loadN,
  input  logic             enP,
  input  logic             enT,
  input  logic [WIDTH-1:0] dataIn,
  output logic [WIDTH-1:0] count,
  output logic             carryOut
);

  ctrlStrobe_t strobe;
  logic        asyncClrN;

  generate
    if (ASYNC_CLEAR) begin : g_clrPath
      assign asyncClrN = clearN;
    end else begin : g_noClrPath
      assign asyncClrN = 1'b1;
    end
  endgenerate

  casc_counter_ctrl u_ctrl (
    .clearN (clearN),
    .loadN  (loadN),
    .enP    (enP),
    .enT    (enT),
    .strobe (strobe)
  );

  casc_counter_dp #(
    .WIDTH       (WIDTH),
    .ASYNC_CLEAR (ASYNC_CLEAR)
  ) u_dp (
    .clk       (clk),
    .asyncClrN (asyncClrN),
    .strobe    (strobe),
    .dataIn    (dataIn),
    .enT       (enT),
    .count     (count),
    .carryOut  (carryOut)
  );

endmodule

// File: rtl/casc_counter_chk.sv
module casc_counter_chk #(
  parameter int WIDTH       = 4,
  parameter bit ASYNC_CLEAR = 1'b0
) (
  input logic             clk,
  input logic             clearN,
  input logic             loadN,
  input logic             enP,
  input logic             enT,
  input logic [WIDTH-1:0] dataIn,
  input logic [WIDTH-1:0] count,
  input logic             carryOut
);

  // Becomes set once a clear has been sampled, so the count is defined.
  logic armed = 1'b0;
  always_ff @(posedge clk) begin
    if (!clearN) armed <= 1'b1;
  end

  logic inClr;
  assign inClr = ASYNC_CLEAR ? !clearN : 1'b0;

  generate
    if (ASYNC_CLEAR) begin : g_asyncProps
      // R1
      async_clear_zero_chk: assert property (@(posedge clk)
        !clearN |-> count == '0);
    end else begin : g_syncProps
      // R2
      sync_clear_edge_chk: assert property (@(posedge clk) disable iff (!armed)
        !clearN |=> count == '0);
    end
  endgenerate

  // R3
  load_copies_data_chk: assert property (@(posedge clk) disable iff (!armed || inClr)
    clearN && !loadN |=> count == $past(dataIn));

  // R4
  count_step_chk: assert property (@(posedge clk) disable iff (!armed || inClr)
    clearN && loadN && enP && enT |=> count == $past(count) + 1'b1);

  // R5
  hold_value_chk: assert property (@(posedge clk) disable iff (!armed || inClr)
    clearN && loadN && !(enP && enT) |=> $stable(count));

  // R6
  carry_needs_t_chk: assert property (@(posedge clk) disable iff (!armed)
    carryOut |-> enT);

  // R6
  carry_at_top_chk: assert property (@(posedge clk) disable iff (!armed)
    carryOut |-> (&count));

endmodule

bind casc_counter casc_counter_chk #(
  .WIDTH       (WIDTH),
  .ASYNC_CLEAR (ASYNC_CLEAR)
) chkInst (
  .clk      (clk),
  .clearN   (clearN),
  .loadN    (loadN),
  .enP      (enP),
  .enT      (enT),
  .dataIn   (dataIn),
  .count    (count),
  .carryOut (carryOut)
);

// File: tb/casc_counter_test.sv
`timescale 1ns/1ps
module casc_counter_test;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  int nChecks = 0;
  int nErrors = 0;
  bit finished = 1'b0;

  // shared stimulus for the single-stage instances
  logic       clearN = 1'b0, aClrN = 1'b0, loadN = 1'b1, enP = 1'b0, enT = 1'b0;
  logic [3:0] dataIn = 4'h0;
  logic [3:0] uCount, aCount;
  logic       uCarry, aCarry;

  casc_counter uut (
    .clk(clk), .clearN(clearN), .loadN(loadN), .enP(enP), .enT(enT),
    .dataIn(dataIn), .count(uCount), .carryOut(uCarry));

  casc_counter #(.WIDTH(4), .ASYNC_CLEAR(1'b1)) asyncInst (
    .clk(clk), .clearN(aClrN), .loadN(loadN), .enP(enP), .enT(enT),
    .dataIn(dataIn), .count(aCount), .carryOut(aCarry));

  // two-stage cascade
  logic       casClrN = 1'b0, casEn = 1'b0;
  logic [3:0] loCount, hiCount;
  logic       loCarry, hiCarry;

  casc_counter loStage (
    .clk(clk), .clearN(casClrN), .loadN(1'b1), .enP(casEn), .enT(casEn),
    .dataIn(4'h0), .count(loCount), .carryOut(loCarry));

  casc_counter hiStage (
    .clk(clk), .clearN(casClrN), .loadN(1'b1), .enP(casEn), .enT(loCarry),
    .dataIn(4'h0), .count(hiCount), .carryOut(hiCarry));

  // modulo-10 counter, clear decoded from the count
  localparam int MOD_N = 10;
  logic       modBootN = 1'b0;
  logic [3:0] modCount;
  logic       modCarry;
  logic       modClrN;
  assign modClrN = modBootN && (modCount != 4'(MOD_N - 1));

  casc_counter modInst (
    .clk(clk), .clearN(modClrN), .loadN(1'b1), .enP(1'b1), .enT(1'b1),
    .dataIn(4'h0), .count(modCount), .carryOut(modCarry));

  // behavioural reference state
  int    uRef = 0, aRef = 0, casTicks = 0, modTicks = 0;
  string uTag = "R2", aTag = "R1";

  always @(posedge clk) begin
    if (!clearN)          begin uRef = 0;                 uTag = "R2"; end
    else if (!loadN)      begin uRef = int'(dataIn);      uTag = "R3"; end
    else if (enP && enT)  begin uRef = (uRef + 1) % 16;   uTag = "R4"; end
    else                  begin                           uTag = "R5"; end

    if (!aClrN)           begin aRef = 0;                 aTag = "R1"; end
    else if (!loadN)      begin aRef = int'(dataIn);      aTag = "R3"; end
    else if (enP && enT)  begin aRef = (aRef + 1) % 16;   aTag = "R4"; end
    else                  begin                           aTag = "R5"; end

    if (!casClrN)   casTicks = 0;
    else if (casEn) casTicks = (casTicks + 1) % 256;

    if (!modBootN) modTicks = 0;
    else           modTicks = modTicks + 1;
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nErrors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // compare every clock, away from the active edge
  always @(negedge clk) begin
    if (!finished) begin
      check(uTag, 32'(uCount), 32'(uRef));
      check("R6", 32'(uCarry), 32'(enT && uRef == 15));
      check(aTag, 32'(aCount), 32'(aRef));
      check("R7", 32'({hiCount, loCount}), 32'(casTicks));
      check("R8", 32'(modCount), 32'(modTicks % MOD_N));
    end
  end

  task automatic nextCycle();
    @(negedge clk);
    #1;
  endtask

  initial begin
    nextCycle();
    nextCycle();
    clearN = 1'b1; aClrN = 1'b1; casClrN = 1'b1; modBootN = 1'b1;

    // R3: load overrides disabled enables
    loadN = 1'b0; dataIn = 4'hA; enP = 1'b0; enT = 1'b0;
    nextCycle();
    loadN = 1'b0; dataIn = 4'hD; enP = 1'b1; enT = 1'b1;
    nextCycle();
    loadN = 1'b1;
    // R4 / R6: count through the wrap with carry visible
    repeat (4) nextCycle();
    // R6: carry follows enT without an edge
    loadN = 1'b0; dataIn = 4'hF; nextCycle();
    loadN = 1'b1; enT = 1'b0; enP = 1'b1;
    #1 check("R6", 32'(uCarry), 32'd0);
    enT = 1'b1;
    #1 check("R6", 32'(uCarry), 32'd1);
    nextCycle();
    // R5: each enable low on its own holds
    enP = 1'b0; enT = 1'b1; repeat (2) nextCycle();
    enP = 1'b1; enT = 1'b0; repeat (2) nextCycle();

    // R1 vs R2: clear dropped between edges
    loadN = 1'b0; dataIn = 4'h7; nextCycle();
    loadN = 1'b1; enP = 1'b0; enT = 1'b0;
    #1;
    clearN = 1'b0; aClrN = 1'b0;
    #1;
    check("R1", 32'(aCount), 32'd0);
    check("R2", 32'(uCount), 32'd7);
    nextCycle();
    clearN = 1'b1; aClrN = 1'b1;

    // R2: clear wins over load and count
    loadN = 1'b0; dataIn = 4'h5; enP = 1'b1; enT = 1'b1; nextCycle();
    clearN = 1'b0; nextCycle();
    clearN = 1'b1; loadN = 1'b1;

    // random mixes of all controls
    for (int i = 0; i < 300; i++) begin
      clearN = ($urandom_range(15) != 0);
      aClrN  = ($urandom_range(15) != 0);
      loadN  = ($urandom_range(7) != 0);
      enP    = ($urandom_range(3) != 0);
      enT    = ($urandom_range(3) != 0);
      dataIn = 4'($urandom_range(15));
      casEn  = ($urandom_range(7) != 0);
      nextCycle();
    end

    // R7: long enabled run through the full 8-bit cycle
    casEn = 1'b1; clearN = 1'b1; aClrN = 1'b1;
    repeat (300) nextCycle();
    casEn = 1'b0; repeat (3) nextCycle();
    casEn = 1'b1; repeat (20) nextCycle();

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", nErrors, nChecks);
    $finish;
  end

  initial begin
    #200000;
    if (!finished) begin
      finished = 1'b1;
      nChecks++;
      nErrors++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("Result: errors=%0d of %0d checks", nErrors, nChecks);
      $finish;
    end
  end

endmodule